// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block remaps bus addresses that fall inside a fixed aperture window onto physical pages. It holds one entry per 4 KiB page of the aperture. Each entry carries a valid flag and a physical page number. A translation port takes a request address and, one cycle later, returns either a hit with the physical address or a fault.

Software never sees the table as an array. It reaches the table through a small register window. It first latches an aperture address in a pointer register. It then writes or reads a data register, which acts on the entry that owns the latched address. A configuration bit turns translation on and off. The aperture base and the page count are parameters.

Top module: `aper_remap`

## Requirements
- R1: After reset, translation is disabled, every table entry is zero, the pointer register is zero, `regRdata` is zero, and `xlValid`, `xlHit`, `xlFault` and `xlPhys` are all zero.
- R2: A register write at byte offset 0x0 (`regAddr[3:2]`=0) stores `regWdata[0]` as the translation enable, and ignores the other bits. A read at offset 0x0 returns the enable in bit 0, with zero in all other bits.
- R3: A write at offset 0x4 latches the full 32-bit value as the entry pointer. A read at offset 0x4 returns that value unchanged. A read at offset 0xC returns zero, and a write there changes nothing.
- R4: A write at offset 0x8 updates the entry with index (pointer − base) >> 12. Bit 31 of the written value becomes the valid flag, and bits 30:12 become the physical page number. Bits 11:0 are discarded. A read at offset 0x8 returns that entry, with bit 31 holding the flag, bits 30:12 holding the page number, and bits 11:0 reading as zero.
- R5: While the pointer lies outside [base, base + pages×4096), a data write changes no entry and a data read returns zero.
- R6: Register read data appears on `regRdata` in the cycle after the read access and holds until the next read.
- R7: A request inside the aperture, with translation enabled and a valid entry, gives `xlHit`=1 and `xlFault`=0. In that case `xlPhys` = {1'b0, page number, request bits 11:0}.
- R8: A request below the base or at or above base + pages×4096 faults, and its `xlPhys` is zero.
- R9: A request to an entry whose valid flag is clear faults. This includes an entry unmapped by writing zero.
- R10: A request made while translation is disabled faults.
- R11: The result of every request is registered. `xlValid` is high exactly in the cycle after each request, with exactly one of `xlHit`/`xlFault` set. When there is no request, all result outputs are low.
- R12: A table write is seen by a request issued in the following cycle. A request in the same cycle as the write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access strobe, one cycle per access |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 4 | Byte offset in the register window |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Registered read data |
| xlReq | input | 1 | Translation request |
| xlAddr | input | 32 | Bus address to translate |
| xlValid | output | 1 | Result strobe |
| xlHit | output | 1 | Translation succeeded |
| xlFault | output | 1 | Translation failed |
| xlPhys | output | 32 | Physical address, zero on fault |

## Verification
The assertions assume that `regSel` and `xlReq` are single-cycle strobes. They also assume that `regAddr`, `regWdata` and `xlAddr` are stable only in the cycle their strobe is high. The checker keeps its own copy of the enable bit by watching writes at offset 0x0, so it assumes that no other path changes the enable. The bench drives every input at the falling edge and holds it for exactly one cycle. It samples results at the next falling edge. It issues a same-cycle write and request only in the scenario that tests the ordering between them.

// File: rtl/aper_remap_pkg.sv
package aper_remap_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int PFN_W      = 19;   // physical page number held in bits 30:12

  typedef enum logic [1:0] {
    RD_CFG   = 2'd0,
    RD_PTR   = 2'd1,
    RD_ENTRY = 2'd2,
    RD_NONE  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   cfgWr;
    logic   ptrWr;
    logic   entryWr;
    logic   rdEn;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;

  typedef struct packed {
    logic             valid;
    logic [PFN_W-1:0] pfn;
  } pageEntry_t;

  function automatic logic inWindow(input logic [31:0] addr,
                                    input logic [31:0] base,
                                    input logic [32:0] span);
    logic [32:0] a33;
    logic [32:0] b33;
    a33 = {1'b0, addr};
    b33 = {1'b0, base};
    return (a33 >= b33) && (a33 < b33 + span);
  endfunction

endpackage

// File: rtl/aper_remap_ctrl.sv
module aper_remap_ctrl
  import aper_remap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWrite,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  input  logic [31:0] tblRdData,
  output ctrlStrobe_t strobe,
  output logic        enable,
  output logic [31:0] entryPtr,
  output logic [31:0] regRdata
);

  logic [1:0] regIdx;
  assign regIdx = regAddr[3:2];

  always_comb begin
    strobe = '0;
    strobe.rdSrc = RD_NONE;
    if (regSel) begin
      if (regWrite) begin
        strobe.cfgWr   = (regIdx == 2'd0);
        strobe.ptrWr   = (regIdx == 2'd1);
        strobe.entryWr = (regIdx == 2'd2);
      end else begin
        strobe.rdEn = 1'b1;
        unique case (regIdx)
          2'd0:    strobe.rdSrc = RD_CFG;
          2'd1:    strobe.rdSrc = RD_PTR;
          2'd2:    strobe.rdSrc = RD_ENTRY;
          default: strobe.rdSrc = RD_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      entryPtr <= '0;
    end else begin
      if (strobe.cfgWr) enable   <= regWdata[0];
      if (strobe.ptrWr) entryPtr <= regWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (strobe.rdEn) begin
      unique case (strobe.rdSrc)
        RD_CFG:   regRdata <= {31'd0, enable};
        RD_PTR:   regRdata <= entryPtr;
        RD_ENTRY: regRdata <= tblRdData;
        default:  regRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/aper_remap_dp.sv
module aper_remap_dp
  import aper_remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h4000_0000,
  parameter int          PAGE_COUNT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        enable,
  input  logic [31:0] entryPtr,
  input  logic [31:0] regWdata,
  input  logic        xlReq,
  input  logic [31:0] xlAddr,
  output logic [31:0] tblRdData,
  output logic        xlValid,
  output logic        xlHit,
  output logic        xlFault,
  output logic [31:0] xlPhys
);

  localparam int          IDX_W     = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
  localparam logic [32:0] APER_SPAN = 33'(PAGE_COUNT) << PAGE_SHIFT;

  pageEntry_t tbl [PAGE_COUNT];

  // pointer side
  logic [31:0]      ptrOff;
  logic [IDX_W-1:0] ptrIdx;
  logic             ptrIn;
  assign ptrOff = entryPtr - APER_BASE;
  assign ptrIdx = ptrOff[PAGE_SHIFT +: IDX_W];
  assign ptrIn  = inWindow(entryPtr, APER_BASE, APER_SPAN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < PAGE_COUNT; k++) tbl[k] <= '0;
    end else if (strobe.entryWr && ptrIn) begin
      tbl[ptrIdx].valid <= regWdata[31];
      tbl[ptrIdx].pfn   <= regWdata[30:PAGE_SHIFT];
    end
  end

  always_comb begin
    tblRdData = '0;
    if (ptrIn)
      tblRdData = {tbl[ptrIdx].valid, tbl[ptrIdx].pfn, {PAGE_SHIFT{1'b0}}};
  end

  // translation side
  logic [31:0]      reqOff;
  logic [IDX_W-1:0] reqIdx;
  logic             reqIn;
  pageEntry_t       reqEnt;
  logic             reqHit;
  assign reqOff = xlAddr - APER_BASE;
  assign reqIdx = reqOff[PAGE_SHIFT +: IDX_W];
  assign reqIn  = inWindow(xlAddr, APER_BASE, APER_SPAN);
  assign reqEnt = reqIn ? tbl[reqIdx] : '0;
  assign reqHit = enable && reqIn && reqEnt.valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlValid <= 1'b0;
      xlHit   <= 1'b0;
      xlFault <= 1'b0;
      xlPhys  <= '0;
    end else begin
      xlValid <= xlReq;
      xlHit   <= xlReq && reqHit;
      xlFault <= xlReq && !reqHit;
      xlPhys  <= (xlReq && reqHit) ?
                 {1'b0, reqEnt.pfn, xlAddr[PAGE_SHIFT-1:0]} : '0;
    end
  end

endmodule

// File: rtl/aper_remap.sv
module aper_remap
  import aper_remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h4000_0000,
  parameter int          PAGE_COUNT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWrite,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        xlReq,
  input  logic [31:0] xlAddr,
  output logic        xlValid,
  output logic        xlHit,
  output logic        xlFault,
  output logic [31:0] xlPhys
);

  ctrlStrobe_t strobe;
  logic        enable;
  logic [31:0] entryPtr;
  logic [31:0] tblRdData;

  aper_remap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regSel(regSel), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .tblRdData(tblRdData),
    .strobe(strobe), .enable(enable), .entryPtr(entryPtr),
    .regRdata(regRdata)
  );

  aper_remap_dp #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .enable(enable), .entryPtr(entryPtr),
    .regWdata(regWdata), .xlReq(xlReq), .xlAddr(xlAddr),
    .tblRdData(tblRdData), .xlValid(xlValid), .xlHit(xlHit),
    .xlFault(xlFault), .xlPhys(xlPhys)
  );

endmodule

// File: rtl/aper_remap_chk.sv
module aper_remap_chk #(
  parameter logic [31:0] APER_BASE  = 32'h4000_0000,
  parameter int          PAGE_COUNT = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        regSel,
  input logic        regWrite,
  input logic [3:0]  regAddr,
  input logic [31:0] regWdata,
  input logic [31:0] regRdata,
  input logic        xlReq,
  input logic [31:0] xlAddr,
  input logic        xlValid,
  input logic        xlHit,
  input logic        xlFault,
  input logic [31:0] xlPhys
);

  localparam logic [32:0] SPAN = 33'(PAGE_COUNT) * 33'd4096;

  logic enShadow;
  always_ff @(posedge clk) begin
    if (!rstN) enShadow <= 1'b0;
    else if (regSel && regWrite && regAddr[3:2] == 2'd0) enShadow <= regWdata[0];
  end

  logic reqOutside;
  assign reqOutside = ({1'b0, xlAddr} < {1'b0, APER_BASE}) ||
                      ({1'b0, xlAddr} >= {1'b0, APER_BASE} + SPAN);

  // R11
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlReq |=> xlValid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xlReq |=> (!xlValid && !xlHit && !xlFault));

  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlValid |-> ($countones({xlHit, xlFault}) == 1));

  // R8
  fault_no_phys_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlFault |-> (xlPhys == 32'd0));

  // R8
  outside_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && reqOutside) |=> xlFault);

  // R10
  disabled_faults_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && !enShadow) |=> xlFault);

  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlReq |=> (!xlHit || xlPhys[11:0] == $past(xlAddr[11:0])));

endmodule

bind aper_remap aper_remap_chk #(.APER_BASE(APER_BASE), .PAGE_COUNT(PAGE_COUNT)) u_chk (.*);

// File: tb/aper_remap_tb.sv
module aper_remap_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h4000_0000;
  localparam int          PAGES      = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regSel, regWrite;
  logic [3:0]  regAddr;
  logic [31:0] regWdata, regRdata;
  logic        xlReq;
  logic [31:0] xlAddr;
  logic        xlValid, xlHit, xlFault;
  logic [31:0] xlPhys;

  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aper_remap #(.APER_BASE(BASE), .PAGE_COUNT(PAGES)) u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .xlReq(xlReq), .xlAddr(xlAddr), .xlValid(xlValid), .xlHit(xlHit),
    .xlFault(xlFault), .xlPhys(xlPhys)
  );

  function automatic logic [31:0] pg(input int k);
    return BASE + 32'(k) * 32'd4096;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regSel = 1'b0;
    d = regRdata;
  endtask

  task automatic xlate(input logic [31:0] a, output logic v, output logic h,
                       output logic f, output logic [31:0] p);
    @(negedge clk);
    xlReq = 1'b1; xlAddr = a;
    @(negedge clk);
    xlReq = 1'b0;
    v = xlValid; h = xlHit; f = xlFault; p = xlPhys;
  endtask

  task automatic expectFault(input string req, input logic [31:0] a);
    logic v, h, f; logic [31:0] p;
    xlate(a, v, h, f, p);
    check(req, "fault valid/hit/fault", {29'd0, v, h, f}, 32'b101);
    check(req, "fault phys", p, 32'd0);
  endtask

  task automatic expectHit(input string req, input logic [31:0] a, input logic [31:0] ph);
    logic v, h, f; logic [31:0] p;
    xlate(a, v, h, f, p);
    check(req, "hit valid/hit/fault", {29'd0, v, h, f}, 32'b110);
    check(req, "hit phys", p, ph);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1", "idle result", {28'd0, xlValid, xlHit, xlFault, 1'b0}, 32'd0);
    check("R1", "idle phys", xlPhys, 32'd0);
    check("R1", "rdata", regRdata, 32'd0);
    regRd(4'h0, d); check("R1", "enable", d, 32'd0);
    regRd(4'h4, d); check("R1", "pointer", d, 32'd0);
    regWr(4'h4, pg(7));
    regRd(4'h8, d); check("R1", "entry 7 zero", d, 32'd0);
    expectFault("R1", pg(7));
  endtask

  task automatic t_config();
    logic [31:0] d;
    regWr(4'h0, 32'd1);
    regRd(4'h0, d); check("R2", "enable set", d, 32'd1);
    regWr(4'h0, 32'hFFFF_FFFE);
    regRd(4'h0, d); check("R2", "only bit0 kept", d, 32'd0);
    regWr(4'h0, 32'd1);
    regWr(4'hC, 32'hFFFF_FFFF);
    regRd(4'hC, d); check("R3", "offset C reads zero", d, 32'd0);
    regRd(4'h0, d); check("R3", "offset C write harmless", d, 32'd1);
  endtask

  task automatic t_entry();
    logic [31:0] d;
    regWr(4'h4, pg(3) + 32'h123);
    regRd(4'h4, d); check("R3", "pointer readback", d, pg(3) + 32'h123);
    regWr(4'h8, 32'h8001_2ABC);
    regRd(4'h8, d); check("R4", "entry readback", d, 32'h8001_2000);
    // R6: value held after read without new access
    @(negedge clk); check("R6", "rdata held", regRdata, 32'h8001_2000);
    expectHit("R7", pg(3) + 32'h456, 32'h0001_2456);
    regWr(4'h4, pg(PAGES-1));
    regWr(4'h8, 32'hFFFF_FFFF);
    regRd(4'h8, d); check("R4", "last entry", d, 32'hFFFF_F000);
    expectHit("R7", pg(PAGES-1) + 32'hFFF, 32'h7FFF_FFFF);
    expectHit("R7", pg(3), 32'h0001_2000);
  endtask

  task automatic t_range();
    logic [31:0] d;
    expectFault("R8", BASE - 32'd4);
    expectFault("R8", pg(PAGES));
    regWr(4'h4, pg(PAGES));
    regWr(4'h8, 32'h8000_5000);
    regRd(4'h8, d); check("R5", "outside read zero", d, 32'd0);
    regWr(4'h4, pg(0));
    regRd(4'h8, d); check("R5", "entry 0 untouched", d, 32'd0);
    expectFault("R5", pg(0) + 32'h10);
  endtask

  task automatic t_unmap();
    expectFault("R9", pg(2));
    regWr(4'h4, pg(3));
    regWr(4'h8, 32'd0);
    expectFault("R9", pg(3) + 32'h8);
  endtask

  task automatic t_disable();
    regWr(4'h0, 32'd0);
    expectFault("R10", pg(PAGES-1));
    regWr(4'h0, 32'd1);
    expectHit("R10", pg(PAGES-1), 32'h7FFF_F000);
  endtask

  task automatic t_timing();
    regWr(4'h4, pg(5));
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = 4'h8; regWdata = 32'h8000_7000;
    xlReq = 1'b1; xlAddr = pg(5) + 32'h10;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0; xlReq = 1'b0;
    check("R12", "same-cycle sees old", {30'd0, xlHit, xlFault}, 32'b01);
    expectHit("R12", pg(5) + 32'h10, 32'h0000_7010);
    // R11: back-to-back requests, one result each
    @(negedge clk);
    xlReq = 1'b1; xlAddr = pg(5) + 32'h20;
    @(negedge clk);
    xlAddr = pg(9);
    check("R11", "first of pair", {29'd0, xlValid, xlHit, xlFault}, 32'b110);
    check("R11", "first phys", xlPhys, 32'h0000_7020);
    @(negedge clk);
    xlReq = 1'b0;
    check("R11", "second of pair", {29'd0, xlValid, xlHit, xlFault}, 32'b101);
    @(negedge clk);
    check("R11", "idle after pair", {29'd0, xlValid, xlHit, xlFault}, 32'd0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failCount++;
    testCount++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regSel = 1'b0; regWrite = 1'b0; regAddr = '0; regWdata = '0;
    xlReq = 1'b0; xlAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_config();
    t_entry();
    t_range();
    t_unmap();
    t_disable();
    t_timing();
    finishRun();
  end

endmodule